// File: doc/BRIEF.md
# Two-Channel DMA Engine

This block moves data for two independent channels over a simple bus that has one master and a request/grant handshake. Each channel holds a source address, a destination address, a transfer count, a unit size and a set of mode bits. Each transfer is a read from the source followed by a write of the captured word to the destination. After a transfer, each address either steps by the unit size or stays fixed.

A channel is started in one of two ways. Software can pulse its start input. A peripheral can raise the channel's request line, which the block answers with a one-cycle clear strobe. A terminal-count line marks the final transfer of a job. In cycle-steal mode the bus request is dropped between transfers. In burst mode the bus is held from the first read to the last write. When both channels are waiting, a shared arbiter chooses between them by fixed priority or by round-robin. Each channel has a maskable interrupt that reports completion or a bus error.

Top module: `dma2ch`

## Requirements
- R1: After reset, bus_req, bus_valid, tc, dreq_clr, ch_en, ch_done, ch_err and irq are all low.
- R2: Each transfer issues a read at the source address and then a write of the returned data to the destination address. bus_size carries the unit (0 byte, 1 half-word, 2 word; 3 acts as word). After each completed transfer, the source or destination address advances by 1, 2 or 4 bytes when its increment bit is set, and stays unchanged when the bit is clear.
- R3: A cfg_count value of N-1 yields exactly N transfers, so 16'hFFFF yields 65536. When the last write completes, ch_done rises and ch_en falls.
- R4: In cycle-steal mode bus_req drops for at least one cycle between transfers, so a job of N transfers raises bus_req N times. In burst mode bus_req rises once per job and stays high through the last write.
- R5: bus_valid is asserted only while bus_req and bus_gnt are both high. Address, direction and size hold steady until bus_ready.
- R6: With rr_mode low, channel 0 is served whenever both channels are pending.
- R7: With rr_mode high and both channels pending, the channel served most recently loses. Two equal jobs therefore interleave 0,1,0,1.
- R8: In software mode, one sw_req pulse runs the whole job.
- R9: In request mode, sw_req has no effect. A cycle-steal channel performs one transfer for each dreq assertion, and dreq must be seen low before the next assertion counts. A burst channel runs the whole job on a single assertion. Each served assertion ends with a one-cycle dreq_clr pulse.
- R10: tc for a channel is high during both phases of that channel's final transfer, and at no other time.
- R11: irq of a channel equals (ch_done or ch_err) AND that channel's interrupt enable. A reload clears it.
- R12: A bus_err response on either phase stops that channel, sets ch_err and clears ch_en. No further beats are issued for that channel, and the other channel still runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 2 | Per-channel strobe that latches the cfg_* fields and enables the channel |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_count | input | CW | Number of transfers minus one |
| cfg_size | input | 2 | Unit size code |
| cfg_burst | input | 1 | 1 burst, 0 cycle-steal |
| cfg_src_inc | input | 1 | Source address steps after each transfer |
| cfg_dst_inc | input | 1 | Destination address steps after each transfer |
| cfg_ext | input | 1 | 1 request-line trigger, 0 software trigger |
| cfg_irq_en | input | 1 | Interrupt enable |
| rr_mode | input | 1 | 1 round-robin, 0 fixed priority |
| sw_req | input | 2 | Software start pulse per channel |
| dreq | input | 2 | Peripheral request per channel |
| dreq_clr | output | 2 | One-cycle request clear per channel |
| tc | output | 2 | Final-transfer marker per channel |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Command valid |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Command address |
| bus_size | output | 2 | Command unit size |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ready | input | 1 | Command accepted |
| bus_err | input | 1 | Error response, qualified by bus_ready |
| ch_en | output | 2 | Channel enabled |
| ch_done | output | 2 | Job completed |
| ch_err | output | 2 | Job stopped by bus error |
| irq | output | 2 | Per-channel interrupt |

## Verification
The assertions assume the bus side behaves well. The grant stays high for as long as the request is held. bus_err is meaningful only together with bus_ready. A channel is never reloaded while its job is in flight. The bench's bus model raises the grant and the ready in response to the block's own outputs, and raises bus_err only with bus_ready and only on one chosen address. Each new configuration is loaded only after the previous job has drained. The peripheral model drops dreq as soon as it sees the clear strobe.

// File: rtl/dma2_pkg.sv
// Shared constants, types and helpers for the two-channel DMA engine.
// Assumes exactly two channels; the arbiter is written for that count.
package dma2_pkg;
    localparam int NCH = 2;
    localparam int CHW = $clog2(NCH);

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } eng_state_t;

    // Number of bytes in one transfer unit; code 3 counts as a word.
    function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/dma2_chan.sv
// One DMA channel: holds the job's addresses, remaining count and mode bits,
// decides when the channel wants the engine, and reports done/error/irq.
// Assumes it is reloaded only while idle and that beat_ok/beat_err are
// single-cycle and only asserted while the engine serves this channel.
module dma2_chan
    import dma2_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_dst,
    input  logic [CW-1:0] ld_cnt,
    input  logic [1:0]    ld_size,
    input  logic          ld_burst,
    input  logic          ld_sinc,
    input  logic          ld_dinc,
    input  logic          ld_ext,
    input  logic          ld_irqen,
    input  logic          sw_req,
    input  logic          dreq,
    input  logic          beat_ok,
    input  logic          beat_err,
    output logic          pend,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [1:0]    size,
    output logic          burst,
    output logic          last,
    output logic          en,
    output logic          done,
    output logic          err,
    output logic          irq,
    output logic          dreq_clr
);
    logic [AW-1:0] src_q, dst_q;
    logic [CW-1:0] rem_q;
    logic [1:0]    size_q;
    logic          burst_q, sinc_q, dinc_q, ext_q, irqen_q;
    logic          en_q, done_q, err_q, run_q, armed_q, clr_q;
    logic [AW-1:0] step;

    // Address step for the programmed unit size.
    always_comb step = {{(AW-3){1'b0}}, unit_bytes(size_q)};

    // Channel state: configuration, progress, triggers and request re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            dst_q   <= '0;
            rem_q   <= '0;
            size_q  <= SZ_BYTE;
            burst_q <= 1'b0;
            sinc_q  <= 1'b0;
            dinc_q  <= 1'b0;
            ext_q   <= 1'b0;
            irqen_q <= 1'b0;
            en_q    <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            run_q   <= 1'b0;
            armed_q <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            clr_q <= 1'b0;
            if (load) begin
                src_q   <= ld_src;
                dst_q   <= ld_dst;
                rem_q   <= ld_cnt;
                size_q  <= ld_size;
                burst_q <= ld_burst;
                sinc_q  <= ld_sinc;
                dinc_q  <= ld_dinc;
                ext_q   <= ld_ext;
                irqen_q <= ld_irqen;
                en_q    <= 1'b1;
                done_q  <= 1'b0;
                err_q   <= 1'b0;
                run_q   <= 1'b0;
                armed_q <= 1'b0;
            end else begin
                if (beat_err) begin
                    en_q  <= 1'b0;
                    err_q <= 1'b1;
                    run_q <= 1'b0;
                end else if (beat_ok) begin
                    if (sinc_q) src_q <= src_q + step;
                    if (dinc_q) dst_q <= dst_q + step;
                    if (rem_q == '0) begin
                        en_q   <= 1'b0;
                        done_q <= 1'b1;
                        run_q  <= 1'b0;
                    end else begin
                        rem_q <= rem_q - 1'b1;
                        if (ext_q && !burst_q) run_q <= 1'b0;
                    end
                    if (ext_q && (rem_q == '0 || !burst_q)) clr_q <= 1'b1;
                end else if (en_q && !run_q) begin
                    if (!ext_q && sw_req) begin
                        run_q <= 1'b1;
                    end else if (ext_q && armed_q && dreq) begin
                        run_q   <= 1'b1;
                        armed_q <= 1'b0;
                    end
                end
                if (ext_q && !dreq && !run_q) armed_q <= 1'b1;
            end
        end
    end

    // Outputs seen by the arbiter, the engine and the ports.
    always_comb begin
        pend     = run_q;
        src      = src_q;
        dst      = dst_q;
        size     = size_q;
        burst    = burst_q;
        last     = (rem_q == '0);
        en       = en_q;
        done     = done_q;
        err      = err_q;
        irq      = irqen_q & (done_q | err_q);
        dreq_clr = clr_q;
    end
endmodule

// File: rtl/dma2_arb.sv
// Chooses which pending channel the engine serves next, by fixed priority
// (channel 0 first) or round-robin (last-served channel loses a tie).
// Assumes two channels; 'take' pulses when the engine accepts the pick.
module dma2_arb
    import dma2_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend,
    input  logic           rr_mode,
    input  logic           take,
    output logic [CHW-1:0] pick,
    output logic           any_pend
);
    logic [CHW-1:0] last_q;

    // Pick a winner from the pending set.
    always_comb begin
        any_pend = |pend;
        if (pend[0] && pend[1]) pick = rr_mode ? ~last_q : 1'b0;
        else                    pick = pend[1] ? 1'b1 : 1'b0;
    end

    // Remember the channel most recently taken, for round-robin.
    always_ff @(posedge clk) begin
        if (!rst_n)    last_q <= 1'b1;
        else if (take) last_q <= pick;
    end
endmodule

// File: rtl/dma2_eng.sv
// Shared transfer engine: requests the bus, performs read-then-write for the
// selected channel and either keeps the bus (burst) or releases it.
// Assumes the grant stays high while bus_req is held.
module dma2_eng
    import dma2_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           any_pend,
    input  logic [CHW-1:0] pick,
    output logic           take,
    output logic [CHW-1:0] cur,
    input  logic [AW-1:0]  cur_src,
    input  logic [AW-1:0]  cur_dst,
    input  logic           cur_burst,
    input  logic           cur_last,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic           bus_valid,
    output logic           bus_write,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           bus_ready,
    input  logic           bus_err,
    output logic           beat_ok,
    output logic           beat_err,
    output logic           in_xfer
);
    eng_state_t     st_q;
    logic [CHW-1:0] cur_q;
    logic [DW-1:0]  data_q;

    // Sequencer: idle -> request -> read -> write -> (read | idle).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cur_q  <= '0;
            data_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (any_pend) begin
                    cur_q <= pick;
                    st_q  <= ST_REQ;
                end
                ST_REQ: if (bus_gnt) st_q <= ST_RD;
                ST_RD: if (bus_ready) begin
                    if (bus_err) st_q <= ST_IDLE;
                    else begin
                        data_q <= bus_rdata;
                        st_q   <= ST_WR;
                    end
                end
                ST_WR: if (bus_ready) begin
                    if (!bus_err && cur_burst && !cur_last) st_q <= ST_RD;
                    else                                    st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Bus command and per-beat results.
    always_comb begin
        take      = (st_q == ST_IDLE) && any_pend;
        cur       = cur_q;
        bus_req   = (st_q != ST_IDLE);
        bus_valid = (st_q == ST_RD) || (st_q == ST_WR);
        bus_write = (st_q == ST_WR);
        bus_addr  = (st_q == ST_WR) ? cur_dst : cur_src;
        bus_wdata = data_q;
        beat_ok   = (st_q == ST_WR) && bus_ready && !bus_err;
        beat_err  = bus_valid && bus_ready && bus_err;
        in_xfer   = bus_valid;
    end
endmodule

// File: rtl/dma2ch.sv
// Top of the two-channel DMA engine: two channel instances, the arbiter and
// the shared bus engine, plus per-channel result demux and terminal count.
// Assumes a single bus master and a well-behaved request/grant slave.
module dma2ch
    import dma2_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cfg_load,
    input  logic [AW-1:0]  cfg_src,
    input  logic [AW-1:0]  cfg_dst,
    input  logic [CW-1:0]  cfg_count,
    input  logic [1:0]     cfg_size,
    input  logic           cfg_burst,
    input  logic           cfg_src_inc,
    input  logic           cfg_dst_inc,
    input  logic           cfg_ext,
    input  logic           cfg_irq_en,
    input  logic           rr_mode,
    input  logic [NCH-1:0] sw_req,
    input  logic [NCH-1:0] dreq,
    output logic [NCH-1:0] dreq_clr,
    output logic [NCH-1:0] tc,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic           bus_valid,
    output logic           bus_write,
    output logic [AW-1:0]  bus_addr,
    output logic [1:0]     bus_size,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           bus_ready,
    input  logic           bus_err,
    output logic [NCH-1:0] ch_en,
    output logic [NCH-1:0] ch_done,
    output logic [NCH-1:0] ch_err,
    output logic [NCH-1:0] irq
);
    logic [AW-1:0]  ch_src   [NCH];
    logic [AW-1:0]  ch_dst   [NCH];
    logic [1:0]     ch_size  [NCH];
    logic [NCH-1:0] ch_burst, ch_last, ch_pend, ch_ok, ch_bad;
    logic [CHW-1:0] pick, cur;
    logic           take, any_pend, beat_ok, beat_err, in_xfer;
    logic [AW-1:0]  cur_src, cur_dst;
    logic           cur_burst, cur_last;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dma2_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (cfg_load[i]),
            .ld_src   (cfg_src),
            .ld_dst   (cfg_dst),
            .ld_cnt   (cfg_count),
            .ld_size  (cfg_size),
            .ld_burst (cfg_burst),
            .ld_sinc  (cfg_src_inc),
            .ld_dinc  (cfg_dst_inc),
            .ld_ext   (cfg_ext),
            .ld_irqen (cfg_irq_en),
            .sw_req   (sw_req[i]),
            .dreq     (dreq[i]),
            .beat_ok  (ch_ok[i]),
            .beat_err (ch_bad[i]),
            .pend     (ch_pend[i]),
            .src      (ch_src[i]),
            .dst      (ch_dst[i]),
            .size     (ch_size[i]),
            .burst    (ch_burst[i]),
            .last     (ch_last[i]),
            .en       (ch_en[i]),
            .done     (ch_done[i]),
            .err      (ch_err[i]),
            .irq      (irq[i]),
            .dreq_clr (dreq_clr[i])
        );
    end

    dma2_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (ch_pend),
        .rr_mode  (rr_mode),
        .take     (take),
        .pick     (pick),
        .any_pend (any_pend)
    );

    dma2_eng #(.AW(AW), .DW(DW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_pend  (any_pend),
        .pick      (pick),
        .take      (take),
        .cur       (cur),
        .cur_src   (cur_src),
        .cur_dst   (cur_dst),
        .cur_burst (cur_burst),
        .cur_last  (cur_last),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .bus_err   (bus_err),
        .beat_ok   (beat_ok),
        .beat_err  (beat_err),
        .in_xfer   (in_xfer)
    );

    // Select the served channel's view for the engine and the bus size.
    always_comb begin
        cur_src   = ch_src[cur];
        cur_dst   = ch_dst[cur];
        cur_burst = ch_burst[cur];
        cur_last  = ch_last[cur];
        bus_size  = ch_size[cur];
    end

    // Route beat results to their channel and mark the final transfer.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ch_ok[i]  = beat_ok  && (cur == CHW'(i));
            ch_bad[i] = beat_err && (cur == CHW'(i));
            tc[i]     = in_xfer && (cur == CHW'(i)) && ch_last[i];
        end
    end
endmodule

// File: rtl/dma2ch_chk.sv
// Property checker for dma2ch, attached by bind. Assumes the bus grant is
// held while requested and the bench never reloads a busy channel.
module dma2ch_chk #(
    parameter int AW  = 32,
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_req,
    input logic           bus_gnt,
    input logic           bus_valid,
    input logic           bus_write,
    input logic           bus_ready,
    input logic           bus_err,
    input logic [AW-1:0]  bus_addr,
    input logic [NCH-1:0] dreq_clr,
    input logic [NCH-1:0] tc,
    input logic [NCH-1:0] ch_en,
    input logic [NCH-1:0] ch_done,
    input logic [NCH-1:0] ch_err,
    input logic [NCH-1:0] irq,
    input logic           cur_burst,
    input logic           cur_last
);
    // R5: commands only while the bus is owned
    a_r5_valid_owned: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_req && bus_gnt));

    // R5: a command holds until accepted
    a_r5_cmd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)));

    // R4: burst goes straight from a finished write to the next read
    a_r4_burst_keeps_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_ready && !bus_err && cur_burst && !cur_last)
        |=> (bus_req && bus_valid && !bus_write));

    // R10: at most one channel flagged final, and only during a command
    a_r10_tc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc));
    a_r10_tc_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (|tc) |-> bus_valid);

    for (genvar i = 0; i < NCH; i++) begin : g_prop
        // R9: the clear strobe lasts a single cycle
        a_r9_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
            dreq_clr[i] |=> !dreq_clr[i]);
        // R12: an error leaves the channel disabled
        a_r12_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_err[i]) |-> !ch_en[i]);
        // R11: interrupt only with a cause
        a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (ch_done[i] || ch_err[i]));
        // R3: completion leaves the channel disabled
        a_r3_done_disables: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_done[i]) |-> !ch_en[i]);
    end
endmodule

bind dma2ch dma2ch_chk #(.AW(AW), .NCH(dma2_pkg::NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_ready (bus_ready),
    .bus_err   (bus_err),
    .bus_addr  (bus_addr),
    .dreq_clr  (dreq_clr),
    .tc        (tc),
    .ch_en     (ch_en),
    .ch_done   (ch_done),
    .ch_err    (ch_err),
    .irq       (irq),
    .cur_burst (cur_burst),
    .cur_last  (cur_last)
);

// File: tb/dma2ch_bench.sv
// Bench for dma2ch: a behavioural bus slave and peripheral, and an expected
// beat queue built from the requirements, compared on every clock.
module dma2ch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_load = '0;
    logic [31:0] cfg_src = '0, cfg_dst = '0;
    logic [15:0] cfg_count = '0;
    logic [1:0]  cfg_size = '0;
    logic        cfg_burst = 0, cfg_src_inc = 0, cfg_dst_inc = 0, cfg_ext = 0, cfg_irq_en = 0;
    logic        rr_mode = 0;
    logic [1:0]  sw_req = '0, dreq = '0;
    logic [1:0]  dreq_clr, tc, ch_en, ch_done, ch_err, irq;
    logic        bus_req, bus_valid, bus_write;
    logic        bus_gnt = 0, bus_ready = 0, bus_err = 0;
    logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
    logic [1:0]  bus_size;

    always #4 clk = ~clk;

    dma2ch u_dma2ch (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_count(cfg_count), .cfg_size(cfg_size), .cfg_burst(cfg_burst),
        .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc), .cfg_ext(cfg_ext),
        .cfg_irq_en(cfg_irq_en), .rr_mode(rr_mode), .sw_req(sw_req), .dreq(dreq),
        .dreq_clr(dreq_clr), .tc(tc), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .bus_err(bus_err), .ch_en(ch_en), .ch_done(ch_done),
        .ch_err(ch_err), .irq(irq)
    );

    typedef struct {
        int          ch;
        logic        wr;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] data;
        logic        last;
        string       tag;
    } beat_t;

    beat_t       exp_q[$];
    int          checks = 0, errors = 0;
    int          rises = 0, clr_cnt0 = 0, clr_cnt1 = 0;
    int          bulk_beats = 0, bulk_tc = 0;
    logic        bulk = 0, req_prev = 0, err_en = 0, finished = 0;
    logic [31:0] err_addr = '0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[31:16] + 16'h0101};
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Bus slave, peripheral counters and per-clock beat comparison.
    always @(negedge clk) begin
        bus_gnt   = bus_req;
        bus_ready = bus_valid;
        bus_err   = bus_valid && err_en && (bus_addr == err_addr);
        bus_rdata = pat(bus_addr);
        if (bus_req && !req_prev) rises++;
        req_prev = bus_req;
        if (dreq_clr[0]) clr_cnt0++;
        if (dreq_clr[1]) clr_cnt1++;
        if (rst_n && bus_valid) begin
            if (bulk) begin
                bulk_beats++;
                if (|tc) bulk_tc++;
            end else if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected beat addr", bus_addr, 0);
            end else begin
                beat_t b;
                logic [1:0] tce;
                b = exp_q.pop_front();
                tce = b.last ? (2'b01 << b.ch) : 2'b00;
                check(bus_write == b.wr, b.tag, "direction", bus_write, b.wr);
                check(bus_addr == b.addr, b.tag, "address", bus_addr, b.addr);
                check(bus_size == b.size, "R2", "size", bus_size, b.size);
                check(tc == tce, "R10", "tc", tc, tce);
                if (b.wr) check(bus_wdata == b.data, "R2", "write data", bus_wdata, b.data);
            end
        end
    end

    task automatic plan_xfer(input int ch, input logic [31:0] s0, input logic [31:0] d0,
                             input int k, input int n, input logic [1:0] sz,
                             input logic si, input logic di, input string tag);
        beat_t b;
        int stp;
        logic [31:0] s, d;
        stp = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        s = si ? s0 + k * stp : s0;
        d = di ? d0 + k * stp : d0;
        b.ch = ch; b.size = sz; b.last = (k == n - 1); b.tag = tag;
        b.wr = 1'b0; b.addr = s; b.data = '0;
        exp_q.push_back(b);
        b.wr = 1'b1; b.addr = d; b.data = pat(s);
        exp_q.push_back(b);
    endtask

    task automatic load_ch(input int ch, input logic [31:0] s, input logic [31:0] d,
                           input logic [15:0] cnt, input logic [1:0] sz, input logic bu,
                           input logic si, input logic di, input logic ex, input logic ie);
        @(negedge clk);
        cfg_src = s; cfg_dst = d; cfg_count = cnt; cfg_size = sz; cfg_burst = bu;
        cfg_src_inc = si; cfg_dst_inc = di; cfg_ext = ex; cfg_irq_en = ie;
        cfg_load = 2'b01 << ch;
        @(negedge clk);
        cfg_load = '0;
    endtask

    task automatic kick(input logic [1:0] m);
        @(negedge clk); sw_req = m;
        @(negedge clk); sw_req = '0;
    endtask

    task automatic settle(input int limit);
        int n = 0;
        while ((exp_q.size() != 0 || bus_req) && n < limit) begin
            @(negedge clk); n++;
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2", "beats missing", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic serve_dreq(input int ch);
        int n = 0;
        @(negedge clk); dreq[ch] = 1'b1;
        while (!dreq_clr[ch] && n < 60) begin @(negedge clk); n++; end
        dreq[ch] = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({bus_req, bus_valid} == 2'b00, "R1", "bus idle", {bus_req, bus_valid}, 0);
        check({tc, dreq_clr, ch_en, ch_done, ch_err, irq} == '0, "R1", "flags",
              {tc, dreq_clr, ch_en, ch_done, ch_err, irq}, 0);

        // R8/R4 software cycle-steal job, words, both addresses stepping
        load_ch(0, 32'h1000, 32'h2000, 16'd3, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 4; k++) plan_xfer(0, 32'h1000, 32'h2000, k, 4, 2'd2, 1, 1, "R8");
        rises = 0;
        kick(2'b01);
        settle(200);
        check(rises == 4, "R4", "steal bus_req rises", rises, 4);
        check(ch_done[0] && !ch_en[0], "R3", "done/en", {ch_done[0], ch_en[0]}, 2'b10);
        check(irq[0] == 1'b1, "R11", "irq enabled", irq[0], 1);

        // R4 burst, half-words, fixed destination, interrupt masked
        load_ch(1, 32'h3000, 32'h4000, 16'd2, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) plan_xfer(1, 32'h3000, 32'h4000, k, 3, 2'd1, 1, 0, "R4");
        rises = 0;
        kick(2'b10);
        settle(200);
        check(rises == 1, "R4", "burst bus_req rises", rises, 1);
        check(ch_done[1] && irq[1] == 1'b0, "R11", "masked irq", irq[1], 0);

        // R9 software start ignored in request mode
        load_ch(0, 32'h5000, 32'h6000, 16'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        rises = 0;
        kick(2'b01);
        repeat (10) @(negedge clk);
        check(rises == 0 && ch_en[0], "R9", "sw_req ignored", rises, 0);

        // R9 request-driven cycle steal, bytes: one transfer per request
        for (int k = 0; k < 3; k++) plan_xfer(0, 32'h5000, 32'h6000, k, 3, 2'd0, 1, 1, "R9");
        clr_cnt0 = 0;
        for (int k = 0; k < 3; k++) serve_dreq(0);
        settle(100);
        check(clr_cnt0 == 3, "R9", "clear pulses steal", clr_cnt0, 3);
        check(rises == 3 && ch_done[0], "R9", "steal rises", rises, 3);

        // R9 request-driven burst: one request runs the job
        load_ch(1, 32'h7000, 32'h7100, 16'd2, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) plan_xfer(1, 32'h7000, 32'h7100, k, 3, 2'd2, 0, 1, "R9");
        clr_cnt1 = 0; rises = 0;
        serve_dreq(1);
        settle(100);
        check(clr_cnt1 == 1 && rises == 1, "R9", "burst clear pulses", clr_cnt1, 1);

        // R6 fixed priority: channel 0 job completes first
        rr_mode = 1'b0;
        load_ch(0, 32'h8000, 32'h8100, 16'd1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        load_ch(1, 32'h9000, 32'h9100, 16'd1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 2; k++) plan_xfer(0, 32'h8000, 32'h8100, k, 2, 2'd2, 1, 1, "R6");
        for (int k = 0; k < 2; k++) plan_xfer(1, 32'h9000, 32'h9100, k, 2, 2'd2, 1, 1, "R6");
        kick(2'b11);
        settle(200);

        // R7 round robin: interleaved 0,1,0,1
        rr_mode = 1'b1;
        load_ch(0, 32'hA000, 32'hA100, 16'd1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        load_ch(1, 32'hB000, 32'hB100, 16'd1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 2; k++) begin
            plan_xfer(0, 32'hA000, 32'hA100, k, 2, 2'd2, 1, 1, "R7");
            plan_xfer(1, 32'hB000, 32'hB100, k, 2, 2'd2, 1, 1, "R7");
        end
        kick(2'b11);
        settle(200);

        // R12 bus error on channel 0's second read; channel 1 carries on
        rr_mode = 1'b0;
        err_addr = 32'hC004; err_en = 1'b1;
        load_ch(0, 32'hC000, 32'hC100, 16'd3, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        load_ch(1, 32'hD000, 32'hD100, 16'd1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        plan_xfer(0, 32'hC000, 32'hC100, 0, 4, 2'd2, 1, 1, "R12");
        begin
            beat_t b;
            b.ch = 0; b.wr = 1'b0; b.addr = 32'hC004; b.size = 2'd2; b.data = '0;
            b.last = 1'b0; b.tag = "R12";
            exp_q.push_back(b);
        end
        for (int k = 0; k < 2; k++) plan_xfer(1, 32'hD000, 32'hD100, k, 2, 2'd2, 1, 1, "R12");
        kick(2'b11);
        settle(200);
        err_en = 1'b0;
        check(ch_err[0] && !ch_en[0] && !ch_done[0], "R12", "err/en/done",
              {ch_err[0], ch_en[0], ch_done[0]}, 3'b100);
        check(irq[0] && ch_done[1], "R12", "irq and other channel done", {irq[0], ch_done[1]}, 2'b11);
        load_ch(0, 32'hE000, 32'hE100, 16'd0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        check(!ch_err[0] && !irq[0] && ch_en[0], "R11", "reload clears", {ch_err[0], irq[0]}, 0);

        // R3 full 65536-transfer burst with fixed addresses
        load_ch(0, 32'hF000, 32'hF100, 16'hFFFF, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        bulk = 1'b1; bulk_beats = 0; bulk_tc = 0; rises = 0;
        kick(2'b01);
        begin
            int n = 0;
            while (!ch_done[0] && n < 140000) begin @(negedge clk); n++; end
        end
        repeat (3) @(negedge clk);
        bulk = 1'b0;
        check(bulk_beats == 131072, "R3", "beats for 65536 transfers", bulk_beats, 131072);
        check(bulk_tc == 2 && rises == 1, "R10", "tc beats in long burst", bulk_tc, 2);
        check(ch_done[0] && !ch_en[0], "R3", "long job done", ch_done[0], 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule